// File: doc/BRIEF.md
# Serial Character Transmitter with Deferred Shutdown

This block turns parallel characters into an asynchronous serial stream on a single output line. Each frame starts with one low start bit. The data bits follow, least significant bit first. An optional parity bit comes next, then one or two high stop bits. Bit timing comes from an external baud strobe: every bit lasts exactly one interval between strobes, and the line changes only in the cycle after a strobe. A character can be 5 to 9 bits wide, and the ninth data bit arrives on the same write port as the other eight.

A one-entry holding register sits in front of the shift engine. A character written while a frame is in progress waits there and goes out directly after that frame's final stop bit, with no idle gap between the two frames.

Clearing the enable input never cuts a frame short. The frame in flight runs to its last stop bit, and only then does the block hand the pin back to general-purpose I/O. A transmit-complete pulse marks the end of a frame when nothing is queued behind it.

Top module: `uart_tx_defer`

## Requirements
- R1: After reset `txd` is 1, `txDone` is 0 and `holdFree` is 1. While the engine is idle, `pinOwn` equals `txEnable`.
- R2: When the holding register is full and `txEnable` is 1, the next `baudTick` starts a frame with one low start bit. Every bit lasts from one `baudTick` to the next, and `txd` changes only in the cycle after a `baudTick`.
- R3: Data bits go out least significant bit first. `charSize` values 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 bits, and larger values select 9. Only the selected low bits of `wrData` are sent. The configuration is captured at the start of each frame.
- R4: With `parityEn`=1, one parity bit follows the most significant data bit and precedes the first stop bit. With `parityOdd`=0 the count of ones over the data bits and the parity bit is even; with `parityOdd`=1 it is odd. With `parityEn`=0 no parity bit is sent.
- R5: The stop bits are high. `twoStop`=0 gives one stop bit and `twoStop`=1 gives two.
- R6: `holdFree` is 1 exactly when the holding register is empty. A write (`wrValid`=1) while `holdFree`=1 is captured. A write while `holdFree`=0 is ignored.
- R7: A character already waiting when the final stop bit ends drives its start bit in the very next bit period.
- R8: `txDone` is a one-cycle pulse in the cycle after the `baudTick` that ends the final stop bit, given only when the holding register is empty at that point.
- R9: Clearing `txEnable` during a frame does not shorten it. `pinOwn` stays 1 until the final stop bit ends and drops in the cycle after that `baudTick`.
- R10: While `txEnable` is 0 and no frame is in progress, `pinOwn` is 0, `txd` is 1, and a waiting character does not start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle strobe marking each bit boundary |
| txEnable | input | 1 | Transmitter enable; clearing it takes effect after the current frame |
| wrValid | input | 1 | Write strobe for the holding register |
| wrData | input | 9 | Character to send; bit 8 is the ninth data bit |
| charSize | input | 3 | Data bits per character: 5 plus this value, capped at 9 |
| parityEn | input | 1 | Add a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| twoStop | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial line, high when idle |
| pinOwn | output | 1 | 1 while the transmitter owns the pin |
| txDone | output | 1 | Pulse when the last frame ends and nothing is queued |
| holdFree | output | 1 | Holding register is empty |

## Verification
The bench aims at the boundary between frames. A character queued during a frame has to drive its start bit right after the last stop bit, and a design that inserted an idle bit there would leave `txd` high and raise `txDone` by mistake. Dropping `txEnable` in the middle of a frame checks deferred shutdown: an engine that stopped at once would return `txd` high early or drop `pinOwn` before the stop bits. Random frames cover every character size, both parity senses and both stop counts. A mis-ordered shift or a wrong parity formula therefore shows up as a wrong bit value. A write into a full holding register and a pending character under disable confirm that neither leaks onto the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    SEL_IDLE, SEL_START, SEL_DATA, SEL_PARITY, SEL_STOP
  } lineSel_e;

  typedef struct packed {
    logic     loadShift;
    logic     shiftNext;
    lineSel_e lineSel;
  } txStrobe_t;
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 9,
  parameter int SIZE_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              txEnable,
  input  logic              holdValid,
  input  logic [SIZE_W-1:0] charSize,
  input  logic              parityEn,
  input  logic              twoStop,
  output txStrobe_t         strobe,
  output logic              busy,
  output logic              txDone
);
  localparam int CNT_W = $clog2(MAX_BITS);
  localparam int SPAN  = MAX_BITS - MIN_BITS;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP} state_e;

  state_e           state;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] sizeIdx;
  logic             parOn;
  logic             twoOn;
  logic             stopCnt;
  logic             startOk;
  logic             stopLast;

  always_comb begin
    if (int'(charSize) > SPAN) sizeIdx = CNT_W'(MAX_BITS - 1);
    else                       sizeIdx = CNT_W'(int'(charSize) + MIN_BITS - 1);
  end

  assign startOk  = txEnable && holdValid;
  assign stopLast = (stopCnt == twoOn);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobe.loadShift = baudTick && startOk &&
                       ((state == ST_IDLE) || (state == ST_STOP && stopLast));
    strobe.shiftNext = baudTick && (state == ST_DATA);
    unique case (state)
      ST_START:  strobe.lineSel = SEL_START;
      ST_DATA:   strobe.lineSel = SEL_DATA;
      ST_PARITY: strobe.lineSel = SEL_PARITY;
      ST_STOP:   strobe.lineSel = SEL_STOP;
      default:   strobe.lineSel = SEL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      lastIdx <= '0;
      parOn   <= 1'b0;
      twoOn   <= 1'b0;
      stopCnt <= 1'b0;
      txDone  <= 1'b0;
    end else begin
      txDone <= 1'b0;
      if (strobe.loadShift) begin
        lastIdx <= sizeIdx;
        parOn   <= parityEn;
        twoOn   <= twoStop;
      end
      if (baudTick) begin
        unique case (state)
          ST_IDLE: if (startOk) state <= ST_START;
          ST_START: begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end
          ST_DATA: begin
            if (bitCnt == lastIdx) begin
              state   <= parOn ? ST_PARITY : ST_STOP;
              stopCnt <= 1'b0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_PARITY: begin
            state   <= ST_STOP;
            stopCnt <= 1'b0;
          end
          default: begin
            if (!stopLast) begin
              stopCnt <= 1'b1;
            end else begin
              state  <= startOk ? ST_START : ST_IDLE;
              txDone <= !holdValid;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 9,
  parameter int SIZE_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strobe,
  input  logic                wrValid,
  input  logic [MAX_BITS-1:0] wrData,
  input  logic [SIZE_W-1:0]   charSize,
  input  logic                parityOdd,
  output logic                holdValid,
  output logic                txd
);
  logic [MAX_BITS-1:0] holdReg;
  logic [MAX_BITS-1:0] shiftReg;
  logic [MAX_BITS-1:0] sizeMask;
  logic [MAX_BITS-1:0] maskedData;
  logic                parBit;

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign sizeMask[i] = (i < MIN_BITS) || (i - MIN_BITS < int'(charSize));
  end

  assign maskedData = holdReg & sizeMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdValid <= 1'b0;
      shiftReg  <= '0;
      parBit    <= 1'b0;
    end else begin
      if (wrValid && !holdValid) begin
        holdReg   <= wrData;
        holdValid <= 1'b1;
      end
      if (strobe.loadShift) begin
        shiftReg  <= maskedData;
        parBit    <= (^maskedData) ^ parityOdd;
        holdValid <= 1'b0;
      end else if (strobe.shiftNext) begin
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  always_comb begin
    unique case (strobe.lineSel)
      SEL_START:  txd = 1'b0;
      SEL_DATA:   txd = shiftReg[0];
      SEL_PARITY: txd = parBit;
      default:    txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_defer.sv
module uart_tx_defer
  import uart_tx_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 9,
  parameter int SIZE_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baudTick,
  input  logic                txEnable,
  input  logic                wrValid,
  input  logic [MAX_BITS-1:0] wrData,
  input  logic [SIZE_W-1:0]   charSize,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                twoStop,
  output logic                txd,
  output logic                pinOwn,
  output logic                txDone,
  output logic                holdFree
);
  txStrobe_t strobe;
  logic      holdValid;
  logic      busy;

  uart_tx_ctrl #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnable(txEnable),
    .holdValid(holdValid), .charSize(charSize), .parityEn(parityEn),
    .twoStop(twoStop), .strobe(strobe), .busy(busy), .txDone(txDone)
  );

  uart_tx_dp #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .SIZE_W(SIZE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrValid(wrValid), .wrData(wrData),
    .charSize(charSize), .parityOdd(parityOdd), .holdValid(holdValid), .txd(txd)
  );

  assign pinOwn   = txEnable || busy;
  assign holdFree = !holdValid;
endmodule

// File: rtl/uart_tx_defer_chk.sv
module uart_tx_defer_chk #(
  parameter int MAX_BITS = 9,
  parameter int SIZE_W   = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                baudTick,
  input logic                txEnable,
  input logic                wrValid,
  input logic [MAX_BITS-1:0] wrData,
  input logic [SIZE_W-1:0]   charSize,
  input logic                parityEn,
  input logic                parityOdd,
  input logic                twoStop,
  input logic                txd,
  input logic                pinOwn,
  input logic                txDone,
  input logic                holdFree
);
  // R2
  txd_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txd) |-> $past(baudTick));

  // R8
  done_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> $past(baudTick));

  // R8
  done_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txd);

  // R10
  released_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pinOwn |-> txd);

  // R9
  deferred_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pinOwn) && $past(!txEnable)) |-> $past(baudTick));
endmodule

bind uart_tx_defer uart_tx_defer_chk #(.MAX_BITS(MAX_BITS), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/uart_tx_defer_test.sv
module uart_tx_defer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       txEnable = 1'b0;
  logic       wrValid = 1'b0;
  logic [8:0] wrData = '0;
  logic [2:0] charSize = '0;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       twoStop = 1'b0;
  logic       txd, pinOwn, txDone, holdFree;

  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;
  logic expBits [0:13];
  string expTag [0:13];
  int  expN;

  always #2.5 clk = ~clk;

  uart_tx_defer uut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnable(txEnable),
    .wrValid(wrValid), .wrData(wrData), .charSize(charSize),
    .parityEn(parityEn), .parityOdd(parityOdd), .twoStop(twoStop),
    .txd(txd), .pinOwn(pinOwn), .txDone(txDone), .holdFree(holdFree)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected line sequence: start, data LSB first, optional parity, stop bits.
  task automatic buildFrame(input logic [8:0] d, input int sz, input bit pe,
                            input bit po, input bit two);
    int nb = 5 + sz;
    logic ones = 1'b0;
    expN = 0;
    expBits[expN] = 1'b0; expTag[expN] = "R2 start"; expN++;
    for (int i = 0; i < nb; i++) begin
      expBits[expN] = d[i]; expTag[expN] = "R3 data"; expN++;
      ones ^= d[i];
    end
    if (pe) begin
      expBits[expN] = ones ^ po; expTag[expN] = "R4 parity"; expN++;
    end
    expBits[expN] = 1'b1; expTag[expN] = "R5 stop"; expN++;
    if (two) begin
      expBits[expN] = 1'b1; expTag[expN] = "R5 stop2"; expN++;
    end
  endtask

  task automatic doTick();
    repeat ($urandom_range(0, 3)) @(negedge clk);
    @(negedge clk) baudTick = 1'b1;
    @(negedge clk) baudTick = 1'b0;
  endtask

  task automatic writeChar(input logic [8:0] d);
    @(negedge clk) begin wrValid = 1'b1; wrData = d; end
    @(negedge clk) wrValid = 1'b0;
  endtask

  task automatic setCfg(input int sz, input bit pe, input bit po, input bit two);
    charSize = 3'(sz); parityEn = pe; parityOdd = po; twoStop = two;
  endtask

  // Walk bits from index fromIdx; offAt >= 0 clears the enable before that bit.
  task automatic runFrame(input int fromIdx, input bit nextQueued, input int offAt);
    for (int k = fromIdx; k < expN; k++) begin
      if (k == offAt) @(negedge clk) txEnable = 1'b0;
      doTick();
      check(expTag[k], 9'(txd), 9'(expBits[k]));
      if (offAt >= 0 && k >= offAt) check("R9 pinOwn held", 9'(pinOwn), 9'd1);
    end
    doTick();
    if (nextQueued) begin
      check("R7 back-to-back start", 9'(txd), 9'd0);
      check("R8 no done when queued", 9'(txDone), 9'd0);
    end else begin
      check("R8 done pulse", 9'(txDone), 9'd1);
      check("R5 line high after stop", 9'(txd), 9'd1);
      @(negedge clk);
      check("R8 done one cycle", 9'(txDone), 9'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [8:0] a, b;
    int sz;
    bit pe, po, two;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset txd", 9'(txd), 9'd1);
    check("R1 reset txDone", 9'(txDone), 9'd0);
    check("R1 reset holdFree", 9'(holdFree), 9'd1);
    check("R1 pinOwn follows enable (off)", 9'(pinOwn), 9'd0);
    txEnable = 1'b1;
    @(negedge clk);
    check("R1 pinOwn follows enable (on)", 9'(pinOwn), 9'd1);

    // Directed: 9 bits, odd parity, two stops; then 5 bits, no parity.
    setCfg(4, 1, 1, 1); buildFrame(9'h1A5, 4, 1, 1, 1);
    writeChar(9'h1A5); runFrame(0, 0, -1);
    setCfg(0, 0, 0, 0); buildFrame(9'h1F3, 0, 0, 0, 0);
    writeChar(9'h1F3); runFrame(0, 0, -1);

    // Random frames across all sizes, parity modes and stop counts.
    for (int n = 0; n < 40; n++) begin
      sz = $urandom_range(0, 4); pe = 1'($urandom); po = 1'($urandom);
      two = 1'($urandom); a = 9'($urandom);
      setCfg(sz, pe, po, two); buildFrame(a, sz, pe, po, two);
      writeChar(a); runFrame(0, 0, -1);
    end

    // Back-to-back through the holding register.
    setCfg(3, 1, 0, 0); a = 9'h0C3; b = 9'h05A;
    buildFrame(a, 3, 1, 0, 0);
    writeChar(a);
    doTick(); check("R2 start A", 9'(txd), 9'd0);
    check("R6 hold empty after load", 9'(holdFree), 9'd1);
    writeChar(b);
    check("R6 hold full after write", 9'(holdFree), 9'd0);
    runFrame(1, 1, -1);
    buildFrame(b, 3, 1, 0, 0);
    runFrame(1, 0, -1);

    // Deferred disable mid-frame.
    setCfg(2, 1, 1, 1); a = 9'h055;
    buildFrame(a, 2, 1, 1, 1);
    writeChar(a); runFrame(0, 0, 3);
    check("R9 pin released after frame", 9'(pinOwn), 9'd0);

    // Pending character while disabled; write into full buffer dropped.
    writeChar(9'h0E1);
    for (int t = 0; t < 3; t++) begin
      doTick();
      check("R10 idle line while disabled", 9'(txd), 9'd1);
      check("R10 pin released while disabled", 9'(pinOwn), 9'd0);
    end
    writeChar(9'h01E);
    check("R6 still full", 9'(holdFree), 9'd0);
    setCfg(3, 0, 0, 0); buildFrame(9'h0E1, 3, 0, 0, 0);
    @(negedge clk) txEnable = 1'b1;
    runFrame(0, 0, -1);
    check("R6 second write ignored", 9'(holdFree), 9'd1);
    for (int t = 0; t < 3; t++) begin
      doTick();
      check("R6 nothing follows", 9'(txd), 9'd1);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule